// File: doc/BRIEF.md
# Cascadable Four-Channel Counter/Timer with Vectored Interrupts

This block holds four down-counting channels joined in a chain. A prescaler derived from the system clock frequency produces one tick every 0.0001 s, and channel 0 counts these ticks as a timer. Channels 1 to 3 are counters. Each one counts the zero-count events of the channel before it, so the chain can be set to divide down into hundredths, seconds and minutes. When a channel reaches zero it reloads its time constant by itself and raises its zero-count output for one clock.

Each zero-count event latches the channel's status bit. The bit stays set until a return-from-interrupt that names that channel arrives. A per-channel interrupt enable decides whether the pending status drives the interrupt request. The vector output carries the code of the lowest-numbered channel that is both pending and enabled, so software can tell channels apart and spot a vector it did not expect. Register writes go through a small port that selects a channel and a target: time constant, control, or vector base. The CPU decode logic and the acknowledge bus cycle are outside this block.

Top module: `cascade_timer`

## Requirements
- R1: With channel 0 running and time constant T0 (1..255), `zc_out[0]` pulses every D*T0 clocks, where D = CLK_HZ/TICK_HZ.
- R2: Channel n (n>0) running with time constant Tn decrements once for each pulse of `zc_out[n-1]`, so its zero-count period is Tn times the period of channel n-1.
- R3: Each zero-count pulse lasts one clock and reloads the counter from the time constant. A time constant of 0 counts 2**DW input events, and 1 gives a pulse on every input event.
- R4: A channel whose run bit is clear holds its count and gives no zero-count pulse, even while its input events keep arriving.
- R5: `status[n]` goes high one clock after a `zc_out[n]` pulse and stays high until cleared.
- R6: A return-from-interrupt (`reti_en`=1 with `reti_ch`=n) clears `status[n]` only and leaves other channels' bits unchanged. If a zero-count event of channel n falls in the same cycle, the bit stays set.
- R7: `irq` is high one clock after any channel has both its status bit and its interrupt-enable bit set. The enable bit does not affect the status bit.
- R8: `vec` equals the written base with bits [2:1] replaced by the number of the lowest-numbered pending enabled channel and bit 0 held at 0. It updates one clock after status.
- R9: After reset, `status`, `irq`, `vec` and `zc_out` are all zero and every channel is stopped with interrupts disabled.
- R10: Register writes (`wr_en`=1) decode `wr_sel` as follows: 0 loads the time constant and the counter of channel `wr_ch`, and a write to channel 0 also restarts the prescaler; 1 writes control (bit 0 run, bit 1 interrupt enable); 2 writes the vector base (bits 7:3 kept).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 time constant, 1 control, 2 vector base |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_data | input | 8 | Write data |
| reti_en | input | 1 | Return-from-interrupt detected |
| reti_ch | input | 2 | Channel whose service routine returned |
| zc_out | output | 4 | One-clock zero-count pulse per channel |
| status | output | 4 | Pending status bit per channel |
| irq | output | 1 | Interrupt request |
| vec | output | 8 | Vector of the highest-priority pending channel |

## Verification
A channel's zero-count event and its return-from-interrupt can fall in the same cycle, and the design gives the set priority over the clear. The bench waits until it sees a channel-0 zero-count pulse and drives a return-from-interrupt for channel 0 so that it is sampled on the same edge that sets the status bit. It then expects the bit to read high. A second return-from-interrupt issued away from any event must clear the bit, which shows that the first clear was overridden and not ignored.

// File: rtl/ctq_pkg.sv
package ctq_pkg;
  typedef enum logic [1:0] {
    SEL_TC   = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_BASE = 2'd2
  } wsel_e;

  localparam int CTL_RUN_BIT = 0;
  localparam int CTL_IE_BIT  = 1;
endpackage

// File: rtl/ctq_prescaler.sv
module ctq_prescaler #(
  parameter int DIV = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick_o
);
  logic tick_q;

  generate
    if (DIV <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= ~restart;
      end
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pcnt_q;

      always_ff @(posedge clk) begin
        if (rst || restart) begin
          pcnt_q <= '0;
          tick_q <= 1'b0;
        end else if (pcnt_q == LAST) begin
          pcnt_q <= '0;
          tick_q <= 1'b1;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
          tick_q <= 1'b0;
        end
      end

      // R1: ticks are single-cycle and spaced by the divider
      a_r1_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
      a_r1_counter_bound: assert property (@(posedge clk) disable iff (rst)
        pcnt_q <= LAST);
    end
  endgenerate

  assign tick_o = tick_q;
endmodule

// File: rtl/ctq_channel.sv
module ctq_channel
  import ctq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          tc_we,
  input  logic          ctl_we,
  input  logic [DW-1:0] wdata,
  input  logic          reti_hit,
  output logic          zc_o,
  output logic          status_o,
  output logic          ie_o
);
  logic [DW-1:0] tc_q;
  logic [DW-1:0] cnt_q;
  logic          run_q;
  logic          ie_q;
  logic          zc_q;
  logic          status_q;
  logic          step;
  logic          at_one;

  assign step   = tick_i && run_q;
  assign at_one = (cnt_q == DW'(1));

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (ctl_we) begin
      run_q <= wdata[CTL_RUN_BIT];
      ie_q  <= wdata[CTL_IE_BIT];
    end
  end

  // down counter with automatic reload (0 means 2**DW)
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q  <= '0;
      cnt_q <= '0;
      zc_q  <= 1'b0;
    end else if (tc_we) begin
      tc_q  <= wdata;
      cnt_q <= wdata;
      zc_q  <= 1'b0;
    end else if (step) begin
      zc_q  <= at_one;
      cnt_q <= at_one ? tc_q : cnt_q - 1'b1;
    end else begin
      zc_q  <= 1'b0;
    end
  end

  // pending status: set by own event, cleared by own return; set wins
  always_ff @(posedge clk) begin
    if (rst) status_q <= 1'b0;
    else     status_q <= zc_q | (status_q & ~reti_hit);
  end

  assign zc_o     = zc_q;
  assign status_o = status_q;
  assign ie_o     = ie_q;

  // R5: an event always leaves the status bit set
  a_r5_status_follows_zc: assert property (@(posedge clk) disable iff (rst)
    zc_q |=> status_q);
  // R6: a return with no coinciding event clears the bit
  a_r6_reti_clears: assert property (@(posedge clk) disable iff (rst)
    (reti_hit && !zc_q) |=> !status_q);
  // R6: status only rises after an event
  a_r6_rise_needs_event: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q) |-> $past(zc_q));
  // R4: stopped channel holds its count
  a_r4_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !tc_we) |=> $stable(cnt_q));
  // R4: no event from a stopped channel
  a_r4_stopped_silent: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !ctl_we) |=> !zc_q);
endmodule

// File: rtl/ctq_irq_prio.sv
module ctq_irq_prio #(
  parameter int NCH  = 4,
  parameter int CH_W = 2,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NCH-1:0]       status_i,
  input  logic [NCH-1:0]       ie_i,
  input  logic                 base_we,
  input  logic [DW-CH_W-2:0]   base_d,
  output logic                 irq_o,
  output logic [DW-1:0]        vec_o
);
  logic [DW-CH_W-2:0] base_q;
  logic [NCH-1:0]     pend;
  logic [CH_W-1:0]    sel;
  logic               any;
  logic               irq_q;
  logic [DW-1:0]      vec_q;

  assign pend = status_i & ie_i;

  // lowest channel number wins
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (pend[k]) begin
        sel = CH_W'(k);
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      irq_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      if (base_we) base_q <= base_d;
      irq_q <= any;
      vec_q <= {base_q, sel, 1'b0};
    end
  end

  assign irq_o = irq_q;
  assign vec_o = vec_q;

  // R7: nothing pending and enabled means no request next cycle
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    ((status_i & ie_i) == '0) |=> !irq_q);
  // R7: a pending enabled channel raises the request
  a_r7_irq_raised: assert property (@(posedge clk) disable iff (rst)
    ((status_i & ie_i) != '0) |=> irq_q);
  // R8: vector bit 0 is always clear
  always_comb begin
    if (!rst) a_r8_vec_even: assert (vec_q[0] == 1'b0);
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import ctq_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int DW      = 8,
  parameter int CLK_HZ  = 100_000_000,
  parameter int TICK_HZ = 10_000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [1:0]             wr_sel,
  input  logic [CH_W-1:0]        wr_ch,
  input  logic [DW-1:0]          wr_data,
  input  logic                   reti_en,
  input  logic [CH_W-1:0]        reti_ch,
  output logic [NCH-1:0]         zc_out,
  output logic [NCH-1:0]         status,
  output logic                   irq,
  output logic [DW-1:0]          vec
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int DIV  = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  logic [NCH-1:0] tc_we;
  logic [NCH-1:0] ctl_we;
  logic [NCH-1:0] reti_hit;
  logic [NCH-1:0] zc;
  logic [NCH-1:0] st;
  logic [NCH-1:0] ie;
  logic           base_we;
  logic           pre_tick;

  assign base_we = wr_en && (wr_sel == SEL_BASE);

  ctq_prescaler #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (tc_we[0]),
    .tick_o  (pre_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic tick_in;

    assign tc_we[i]    = wr_en && (wr_sel == SEL_TC)  && (wr_ch == CH_W'(i));
    assign ctl_we[i]   = wr_en && (wr_sel == SEL_CTL) && (wr_ch == CH_W'(i));
    assign reti_hit[i] = reti_en && (reti_ch == CH_W'(i));

    if (i == 0) begin : g_head
      assign tick_in = pre_tick;
    end else begin : g_link
      assign tick_in = zc[i-1];
    end

    ctq_channel #(.DW(DW)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (tick_in),
      .tc_we    (tc_we[i]),
      .ctl_we   (ctl_we[i]),
      .wdata    (wr_data),
      .reti_hit (reti_hit[i]),
      .zc_o     (zc[i]),
      .status_o (st[i]),
      .ie_o     (ie[i])
    );
  end

  ctq_irq_prio #(.NCH(NCH), .CH_W(CH_W), .DW(DW)) u_prio (
    .clk      (clk),
    .rst      (rst),
    .status_i (st),
    .ie_i     (ie),
    .base_we  (base_we),
    .base_d   (wr_data[DW-1:CH_W+1]),
    .irq_o    (irq),
    .vec_o    (vec)
  );

  assign zc_out = zc;
  assign status = st;

  // R2: a downstream event needs an upstream event one cycle earlier
  for (genvar j = 1; j < NCH; j++) begin : g_chk
    a_r2_cascade_cause: assert property (@(posedge clk) disable iff (rst)
      $rose(zc[j]) |-> $past(zc[j-1]));
  end
endmodule

// File: tb/sim_cascade_timer.sv
module sim_cascade_timer;
  localparam int NCH  = 4;
  localparam int CH_W = 2;
  localparam int DW   = 8;
  localparam int NV   = 6;

  // table: time constants for ch0..3, channel measured, expected period
  // rows 0 (R1), 1-3 (R2 cascade), 4-5 (R3 reload 0 -> 256, 1)
  localparam int T0 [NV] = '{5, 5, 2, 2, 0, 1};
  localparam int T1 [NV] = '{3, 3, 2, 2, 1, 1};
  localparam int T2 [NV] = '{1, 1, 2, 2, 1, 1};
  localparam int T3 [NV] = '{1, 1, 1, 2, 1, 1};
  localparam int MC [NV] = '{0, 1, 2, 3, 0, 0};
  localparam int EP [NV] = '{20, 60, 32, 64, 1024, 4};
  localparam int RQ [NV] = '{1, 2, 2, 2, 3, 3};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [1:0]      wr_sel = '0;
  logic [CH_W-1:0] wr_ch = '0;
  logic [DW-1:0]   wr_data = '0;
  logic            reti_en = 1'b0;
  logic [CH_W-1:0] reti_ch = '0;
  logic [NCH-1:0]  zc_out;
  logic [NCH-1:0]  status;
  logic            irq;
  logic [DW-1:0]   vec;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cascade_timer #(.NCH(NCH), .DW(DW), .CLK_HZ(40_000), .TICK_HZ(10_000)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_ch(wr_ch),
    .wr_data(wr_data), .reti_en(reti_en), .reti_ch(reti_ch),
    .zc_out(zc_out), .status(status), .irq(irq), .vec(vec)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int sel, int ch, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel[1:0]; wr_ch = ch[CH_W-1:0]; wr_data = d[DW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reti(int ch);
    @(negedge clk);
    reti_en = 1'b1; reti_ch = ch[CH_W-1:0];
    @(negedge clk);
    reti_en = 1'b0;
  endtask

  task automatic wait_zc(int ch);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (zc_out[ch]) return;
    end
  endtask

  task automatic gap(int ch, output int g);
    wait_zc(ch);
    g = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      g++;
      if (zc_out[ch]) return;
    end
  endtask

  task automatic stop_and_clear();
    for (int c = 0; c < NCH; c++) wr(1, c, 0);
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) reti(c);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1..R10 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int g, c0, c1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 status", int'(status), 0);
    chk("R9 irq", int'(irq), 0);
    chk("R9 vec", int'(vec), 0);
    c0 = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (zc_out != '0) c0++;
    end
    chk("R9 stopped after reset", c0, 0);

    // table walk: R1, R2, R3 periods
    for (int i = 0; i < NV; i++) begin
      wr(0, 3, T3[i]); wr(0, 2, T2[i]); wr(0, 1, T1[i]); wr(0, 0, T0[i]);
      for (int c = 0; c < NCH; c++) wr(1, c, 1);
      gap(MC[i], g);
      chk($sformatf("R%0d period row %0d", RQ[i], i), g, EP[i]);
    end

    // R3 one-clock pulse width
    wr(0, 0, 2);
    wait_zc(0);
    @(negedge clk);
    chk("R3 pulse width", int'(zc_out[0]), 0);

    // R4 stopped channel ignores its input events
    wr(0, 0, 2); wr(1, 0, 1); wr(1, 1, 0);
    c0 = 0; c1 = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (zc_out[0]) c0++;
      if (zc_out[1]) c1++;
    end
    chk("R4 stopped ch1 pulses", c1, 0);
    chk("R4 upstream still active", int'(c0 > 0), 1);

    stop_and_clear();
    chk("R6 cleared all", int'(status), 0);

    // R10 base write; R5 status; R7 gating
    wr(2, 0, 8'hA8);
    wr(0, 0, 3); wr(1, 0, 1);
    wait_zc(0);
    @(negedge clk);
    chk("R5 status set", int'(status[0]), 1);
    @(negedge clk);
    chk("R7 irq gated by ie", int'(irq), 0);
    chk("R7 status kept with ie off", int'(status[0]), 1);
    wr(1, 0, 3);
    @(negedge clk);
    chk("R7 irq raised", int'(irq), 1);
    chk("R10 R8 vec ch0", int'(vec), 8'hA8);

    // R6 coincidence: return sampled on the edge that sets status
    wait_zc(0);
    reti_en = 1'b1; reti_ch = '0;
    @(negedge clk);
    reti_en = 1'b0;
    chk("R6 set wins over clear", int'(status[0]), 1);
    reti(0);
    chk("R6 clear away from event", int'(status[0]), 0);

    stop_and_clear();

    // R8 priority, R6 channel selectivity
    wr(0, 0, 2); wr(0, 1, 1);
    wr(1, 1, 3); wr(1, 0, 3);
    wait_zc(1);
    wr(1, 0, 2);
    repeat (5) @(negedge clk);
    chk("R8 both pending", int'(status), 3);
    chk("R8 lowest first", int'(vec), 8'hA8);
    chk("R7 irq pending", int'(irq), 1);
    reti(2);
    chk("R6 other channel untouched", int'(status), 3);
    reti(0);
    @(negedge clk);
    chk("R6 only ch0 cleared", int'(status), 2);
    chk("R8 next channel vector", int'(vec), 8'hAA);
    reti(1);
    @(negedge clk);
    chk("R7 irq dropped", int'(irq), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule